// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block answers on a two-wire serial bus as a 256-byte EEPROM. Clock and data are brought into the system clock domain, where start and stop conditions and the clock edges are found. The first byte after a start names the target device. Its upper nibble is the fixed type code `1010`, followed by three bits that must equal the strap inputs, and it ends with a direction bit. A write carries a one-byte word address and then data. The data bytes collect in a four-byte page buffer and move into the 256x8 array only when the master sends a stop.

After that commit, the device is busy for a set number of system clocks. During that time it takes no part in bus traffic at all. A read returns bytes from the current address, MSB first, and steps the address after every byte for as long as the master acknowledges. The data line is open drain: the block only ever asks for the line to be pulled low.

Top module: `eep_i2c_slave`

## Requirements
- R1: The address byte is `1010`, then strap bits 2..0, then a direction bit (bit 0; 1 = read, 0 = write). On a match the slave pulls SDA low in the ninth clock. On a mismatch it leaves SDA released through the end of the transfer, including the acknowledge slots of later bytes, until the next start.
- R2: In a write, the word-address byte and every data byte that follows are acknowledged with SDA low in their ninth clock.
- R3: Write data reaches the array only on a stop that ends a write. Data followed by a repeated start leaves the array unchanged and does not set `busy_o`. A committing stop raises `busy_o`.
- R4: Successive data bytes go to successive addresses. Only the low two address bits advance, wrapping within the four-byte page, so a fifth or later byte overwrites earlier bytes of the same page.
- R5: After a commit, `busy_o` stays high for exactly `BUSY_CYCLES` system clocks. While it is high, no address byte is acknowledged.
- R6: A read sends bytes MSB first, starting at the current address. The full 8-bit address increments after each byte, wrapping from 0xFF to 0x00, and the next byte follows each master acknowledge.
- R7: After a master NACK the slave keeps SDA released until the next start.
- R8: After a committed write, the current address points to the byte after the last one written, wrapped within its page.
- R9: A stop that arrives partway through a data byte discards the buffered write: the array is unchanged and `busy_o` stays low.
- R10: A repeated start after a word address begins a new address phase. A read that follows it starts at that word address.
- R11: After reset, SDA is released and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Device select straps compared with address bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | High during the modelled internal write cycle |

## Verification
The assertions take it as given that SDA moves only while SCL is low, except at start and stop conditions. They also assume each SCL level lasts well beyond the synchroniser latency, and that the master never makes a start or stop while the slave is pulling the line low. The line-change property depends on this: it expects the drive enable to change only while SCL is low. The bench's bit tasks keep every quarter bit at eight system clocks. They change data only in the middle of the low phase and release SDA before every acknowledge or read slot, so the stimulus stays inside these limits.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int EEP_ADDR_W = 8;
  localparam int EEP_BYTE_W = 8;
  localparam logic [3:0] EEP_TYPE_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_SKIP
  } eep_state_e;
endpackage

// File: rtl/eep_line_cond.sv
module eep_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_s;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock stays high are bus conditions
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              has_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] pg_data [PAGE_N];
  logic [PAGE_N-1:0] pg_vld;
  logic [BASE_W-1:0] pg_base;

  // valid mask carries control meaning, so it is reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_vld <= '0;
    end else if (buf_clr) begin
      pg_vld <= '0;
    end else if (buf_we) begin
      pg_vld[buf_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_clr) begin
      pg_base <= clr_addr[ADDR_W-1:PAGE_W];
    end
  end

  generate
    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (buf_we && (buf_idx == PAGE_W'(g))) begin
          pg_data[g] <= buf_wdata;
        end
      end
    end
  endgenerate

  // the whole page lands in one clock at commit
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int p = 0; p < PAGE_N; p++) begin
        if (pg_vld[p]) begin
          mem[{pg_base, PAGE_W'(p)}] <= pg_data[p];
        end
      end
    end
  end

  assign rd_data  = mem[rd_addr];
  assign has_data = |pg_vld;
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int PAGE_W      = 2,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int ADDR_W = EEP_ADDR_W;
  localparam int BYTE_W = EEP_BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_ev;
  logic stop_ev;

  eep_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  eep_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              mack_q, mack_d;

  logic              buf_clr;
  logic              buf_we;
  logic              commit;
  logic              has_data;
  logic [BYTE_W-1:0] rd_data;
  logic              busy;
  logic              dev_hit;

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .buf_clr   (buf_clr),
    .clr_addr  (addr_q),
    .buf_we    (buf_we),
    .buf_idx   (addr_q[PAGE_W-1:0]),
    .buf_wdata (sh_q),
    .commit    (commit),
    .rd_addr   (addr_q),
    .rd_data   (rd_data),
    .has_data  (has_data)
  );

  eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (commit),
    .busy  (busy)
  );

  assign dev_hit = (sh_q[7:4] == EEP_TYPE_CODE) && (sh_q[3:1] == strap_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    addr_d  = addr_q;
    mack_d  = mack_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    commit  = 1'b0;

    if (busy) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_ev) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      // a stop is always preceded by one clock rise sampled as a bit
      if ((state_q == ST_WDAT) && (cnt_q <= CNT_W'(1)) && has_data) begin
        commit = 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_DEV, ST_WORD, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == LAST_BIT)) begin
            cnt_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                oe_d    = 1'b1;
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (state_q == ST_WORD) begin
              addr_d  = sh_q;
              oe_d    = 1'b1;
              state_d = ST_WORD_ACK;
            end else begin
              buf_we  = 1'b1;
              addr_d  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              oe_d    = 1'b1;
              state_d = ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (sh_q[0]) begin
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = CNT_W'(1);
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              cnt_d   = '0;
              state_d = ST_WORD;
            end
          end
        end
        ST_WORD_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            buf_clr = 1'b1;
            state_d = ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              addr_d  = addr_q + 1'b1;
              state_d = ST_RDAT_ACK;
            end else begin
              oe_d  = ~sh_q[BYTE_W-2];
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RDAT_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = CNT_W'(1);
              state_d = ST_RDAT;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      addr_q  <= addr_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign busy_o   = busy;
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int BUSY_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic busy,
  input logic stop_ev
);
  logic [31:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (busy) begin
      hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  // R5: no acknowledge while the write cycle runs
  p_quiet_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R5: busy window length in system clocks
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (hi_len == 32'(BUSY_CYCLES)));

  // R3: the write cycle starts only from a stop condition
  p_commit_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // R6: the slave moves the data line only while the clock is low
  p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R7: the line is free once a stop has been seen
  p_free_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind eep_i2c_slave eep_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe_o),
  .busy    (busy_o),
  .stop_ev (stop_ev)
);

// File: tb/sim_eep_i2c_slave.sv
module sim_eep_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QB   = 8;
  localparam int BUSY = 600;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_oe;
  logic busy;
  logic sda_line;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int total;
  int bad;
  int run_len;
  int last_len;

  assign sda_line = sda_m & ~sda_oe;

  eep_i2c_slave #(.PAGE_W(2), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (STRAP),
    .sda_oe_o (sda_oe),
    .busy_o   (busy)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    run_len  = 0;
    last_len = 0;
  end

  always @(negedge clk) begin
    if (busy) begin
      run_len <= run_len + 1;
    end else if (run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    logic [7:0] a;
    forever begin
      while (act_q.size() == 0) @(negedge clk);
      a = act_q.pop_front();
      if (exp_q.size() == 0) begin
        check(1'b0, "SB", a, 0);
      end else begin
        e = exp_q.pop_front();
        check(a == e.val, e.tag, a, e.val);
      end
    end
  end

  task automatic push_exp(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wq();
    repeat (QB) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_page(input logic [7:0] a, input logic [7:0] d [8], input int n);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); check(ack, "R1 write address ack", ack, 1);
    send_byte(a, ack);     check(ack, "R2 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); check(ack, "R2 data ack", ack, 1);
    end
    bus_stop();
    check(busy, "R3 stop starts write cycle", busy, 1);
  endtask

  // word address, repeated start, read n bytes, NACK the last
  task automatic rd_at(input logic [7:0] a, input int n);
    logic ack;
    logic b;
    logic [7:0] v;
    bus_start();
    send_byte(DEV_W, ack); check(ack, "R10 dummy write ack", ack, 1);
    send_byte(a, ack);     check(ack, "R10 word ack", ack, 1);
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R10 read after repeated start", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(v, i < n - 1);
      act_q.push_back(v);
    end
    get_bit(b);
    check(b == 1'b1, "R7 released after NACK", b, 1);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic b;
    logic [7:0] v;
    logic [7:0] d [8];
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check(!sda_oe, "R11 SDA released at reset", sda_oe, 0);
    check(!busy, "R11 busy low at reset", busy, 0);

    // R1: wrong strap, then a later byte is not acknowledged either
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack); check(!ack, "R1 strap mismatch", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R1 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ack); check(!ack, "R1 type mismatch", ack, 0);
    bus_stop();

    // byte write, then R5 no ack while busy, then length
    d[0] = 8'hA5;
    wr_page(8'h10, d, 1);
    bus_start();
    send_byte(DEV_W, ack); check(!ack, "R5 no ack while busy", ack, 0);
    bus_stop();
    wait_ready();
    check(last_len == BUSY, "R5 busy length", last_len, BUSY);

    // R10 / R6 read back
    push_exp(8'hA5, "R6 read byte write");
    rd_at(8'h10, 1);

    // R3: data then repeated start does not commit
    bus_start();
    send_byte(DEV_W, ack); check(ack, "R3 address ack", ack, 1);
    send_byte(8'h10, ack);
    send_byte(8'h99, ack); check(ack, "R2 data ack", ack, 1);
    push_exp(8'hA5, "R3 unchanged without stop");
    rd_at(8'h10, 1);
    check(!busy, "R3 no write cycle", busy, 0);

    // R4 page wrap with six bytes from 0x21
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    d[3] = 8'h44; d[4] = 8'h55; d[5] = 8'h66;
    wr_page(8'h21, d, 6);
    wait_ready();

    // R8 current address read lands on 0x23
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R8 read ack", ack, 1);
    push_exp(8'h33, "R8 current address after page write");
    recv_byte(v, 1'b0);
    act_q.push_back(v);
    get_bit(b); check(b == 1'b1, "R7 released after NACK", b, 1);
    bus_stop();

    push_exp(8'h44, "R4 page slot 0");
    push_exp(8'h55, "R4 page slot 1");
    push_exp(8'h66, "R4 page slot 2");
    push_exp(8'h33, "R4 page slot 3");
    rd_at(8'h20, 4);

    // R6 address wrap 0xFF to 0x00
    d[0] = 8'h5A;
    wr_page(8'hFF, d, 1);
    wait_ready();
    d[0] = 8'hC3;
    wr_page(8'h00, d, 1);
    wait_ready();
    push_exp(8'h5A, "R6 byte at 0xFF");
    push_exp(8'hC3, "R6 wrap to 0x00");
    rd_at(8'hFF, 2);

    // R9 stop partway through a data byte
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h10, ack);
    send_byte(8'h77, ack); check(ack, "R2 data ack", ack, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check(!busy, "R9 mid-byte stop no busy", busy, 0);
    push_exp(8'hA5, "R9 mid-byte stop discards");
    rd_at(8'h10, 1);

    while (act_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "SB expected items left", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule